// File: doc/BRIEF.md
# Windowed Indirect Register Bridge

This block lets a host with a narrow bus reach a large space of 32-bit internal registers through four port addresses. The host stages a 32-bit word as two 16-bit halves, then writes a target address to one of two ports. Writing the commit port sends a single-cycle write strobe with the staged word to the addressed target. Writing the fetch port sends a single-cycle read strobe instead. The bridge then latches the target's reply, one cycle later, into a read register that the host reads back as two halves.

Host reads serve two more purposes. One port returns the head word of an output-data FIFO, and the FIFO advances only after the host read has ended, so the bus value stays steady for the whole access. Another port returns a packed status word built from flags and pins. The host strobes are asynchronous and active low. Each one passes through a synchroniser and an edge detector, and a small state machine turns every host access into exactly one internal action.

States: `S_IDLE` (waiting), `S_WR_HOLD` (a write was acted on; waiting for the host to release the write strobe), `S_RD_LAT` (the read strobe is out to the target), `S_RD_CAP` (the target's reply is captured at the end of this state), `S_RD_HOLD` (a host read is in progress). Transitions: `S_IDLE`→`S_WR_HOLD` on a write edge to any port except fetch; `S_IDLE`→`S_RD_LAT` on a write edge to the fetch port; `S_RD_LAT`→`S_RD_CAP` always; `S_RD_CAP`→`S_WR_HOLD` always; `S_WR_HOLD`→`S_IDLE` when the write strobe is high; `S_IDLE`→`S_RD_HOLD` on a read edge when no write edge is present; `S_RD_HOLD`→`S_IDLE` when the read strobe is high, with the FIFO pop issued on that exit.

Top module: `host_window_bridge`

## Requirements
- R1: A host write to address 0 sets staging bits 15:0, and a write to address 1 sets bits 31:16. `tgt_wdata` always presents the whole 32-bit staging word.
- R2: A host write to address 2 loads the indirect address from `hst_wdata[IADDR_W-1:0]` and produces one single-cycle `tgt_wr_stb`, with `tgt_addr` equal to the new address and `tgt_wdata` equal to the staged word.
- R3: A host write to address 3 loads the same indirect address register and produces one single-cycle `tgt_rd_stb` with no write strobe. The `tgt_rdata` value present in the cycle after the strobe is stored in the read register.
- R4: A host read of address 0 returns read-register bits 15:0, and a read of address 1 returns bits 31:16. The register keeps its value through later writes to addresses 0, 1 and 2 until the next write to address 3.
- R5: A host read of address 2 returns `fifo_data`, which stays steady throughout the read. The bridge raises `fifo_pop` for exactly one cycle after the host read ends.
- R6: A read of address 2 while `fifo_empty` is high gives no `fifo_pop`. The host sees the word the FIFO side is holding.
- R7: A read of address 3 returns the status word, with these bits:
  - bits 15:13 are 0
  - bit 12 is `selftest_ok`
  - bit 11 is the inverse of `reset_pin`
  - bits 10, 9, 8 and 7 are `ch_en[0]`, `ch_en[1]`, `ch_en[2]` and `ch_en[3]`
  - bit 6 is `sync_in`
  - bits 5:2 are the parameter `REV`
  - bit 1 is `lvl_done`
  - bit 0 is `fifo_empty`, so a 0 means new data is waiting
- R8: Host reads never strobe the target. Reads of addresses 0, 1 and 3 never pop the FIFO.
- R9: Each host access produces at most one internal strobe, however long the host holds its strobe low.
- R10: Addresses 4 to 7 are inert. Writes there change nothing and strobe nothing, and reads there return 0.
- R11: After reset, the staging word, the indirect address and the read register are all zero, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 3 | Host port address |
| hst_wdata | input | 16 | Host write data |
| hst_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| hst_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| hst_rdata | output | 16 | Host read data, selected from `hst_addr` |
| tgt_addr | output | IADDR_W | Indirect target address |
| tgt_wdata | output | 32 | Staged write word |
| tgt_wr_stb | output | 1 | Single-cycle target write strobe |
| tgt_rd_stb | output | 1 | Single-cycle target read strobe |
| tgt_rdata | input | 32 | Target reply, valid one cycle after `tgt_rd_stb` |
| fifo_data | input | 16 | Head word of the output FIFO |
| fifo_empty | input | 1 | FIFO has no unread word |
| fifo_pop | output | 1 | Single-cycle FIFO advance |
| selftest_ok | input | 1 | Self-test signature match flag |
| reset_pin | input | 1 | Raw level of the external reset pin |
| ch_en | input | 4 | Channel enable pins |
| sync_in | input | 1 | Sync input pin |
| lvl_done | input | 1 | Level-detector integration done |

## Verification
The assertions check these rules on every cycle:
- Each target strobe and each FIFO pop lasts a single cycle.
- The two target strobes never overlap.
- A pop never follows a cycle in which the FIFO was empty.
- The read register changes only two cycles after a read strobe.
- The top three status bits read as zero.

Only the bench scenarios can show the following:
- The staged word and address are the ones committed.
- Each host access yields exactly one event even when the strobe is held long.
- FIFO words come out in order.
- Inert addresses leave the state untouched.
- The status word carries each field in its place.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_HOLD,
        S_RD_LAT,
        S_RD_CAP,
        S_RD_HOLD
    } hwb_state_t;

    // Port address codes (bits 1:0; bit 2 must be zero)
    localparam logic [1:0] P_LO    = 2'd0;
    localparam logic [1:0] P_HI    = 2'd1;
    localparam logic [1:0] P_COMMIT = 2'd2;
    localparam logic [1:0] P_FETCH = 2'd3;
    localparam logic [1:0] P_FIFO  = 2'd2;
    localparam logic [1:0] P_STAT  = 2'd3;

    localparam int NUM_CH    = 4;
    localparam int NUM_STRB  = 2;

endpackage

// File: rtl/hwb_edge_sync.sv
module hwb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic lvl_n,
    output logic fall
);
    logic [STAGES-1:0] shreg;
    logic              prev_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '1;
            prev_n <= 1'b1;
        end else begin
            shreg  <= {shreg[STAGES-2:0], async_n};
            prev_n <= shreg[STAGES-1];
        end
    end

    assign lvl_n = shreg[STAGES-1];
    assign fall  = prev_n & ~shreg[STAGES-1];
endmodule

// File: rtl/hwb_status_pack.sv
module hwb_status_pack
    import hwb_pkg::*;
#(
    parameter logic [3:0] REV = 4'd3
) (
    input  logic              selftest_ok,
    input  logic              reset_pin,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic              sync_in,
    input  logic              lvl_done,
    input  logic              fifo_empty,
    output logic [15:0]       word
);
    localparam int CH_TOP = 10;

    logic [NUM_CH-1:0] ch_field;

    // Channel 0 sits at the highest bit of the enable field
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_field[NUM_CH-1-i] = ch_en[i];
    end

    always_comb begin
        word                             = '0;
        word[12]                         = selftest_ok;
        word[11]                         = ~reset_pin;
        word[CH_TOP -: NUM_CH]           = ch_field;
        word[6]                          = sync_in;
        word[5:2]                        = REV;
        word[1]                          = lvl_done;
        word[0]                          = fifo_empty;
    end
endmodule

// File: rtl/host_window_bridge.sv
module host_window_bridge
    import hwb_pkg::*;
#(
    parameter int         IADDR_W   = 16,
    parameter int         SYNC_STG  = 2,
    parameter logic [3:0] REV       = 4'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         hst_addr,
    input  logic [15:0]        hst_wdata,
    input  logic               hst_wr_n,
    input  logic               hst_rd_n,
    output logic [15:0]        hst_rdata,
    output logic [IADDR_W-1:0] tgt_addr,
    output logic [31:0]        tgt_wdata,
    output logic               tgt_wr_stb,
    output logic               tgt_rd_stb,
    input  logic [31:0]        tgt_rdata,
    input  logic [15:0]        fifo_data,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    input  logic               selftest_ok,
    input  logic               reset_pin,
    input  logic [NUM_CH-1:0]  ch_en,
    input  logic               sync_in,
    input  logic               lvl_done
);
    localparam int WR_IDX = 0;
    localparam int RD_IDX = 1;

    hwb_state_t         state, state_nx;
    logic [NUM_STRB-1:0] raw_n, lvl_n, fall;
    logic [31:0]        hold;
    logic [31:0]        rd_reg;
    logic [IADDR_W-1:0] iaddr;
    logic               rd_is_fifo;
    logic [15:0]        status_word;
    logic               addr_ok;
    logic               wr_ev, rd_ev;

    assign raw_n = {hst_rd_n, hst_wr_n};

    for (genvar g = 0; g < NUM_STRB; g++) begin : g_sync
        hwb_edge_sync #(.STAGES(SYNC_STG)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_n(raw_n[g]),
            .lvl_n  (lvl_n[g]),
            .fall   (fall[g])
        );
    end

    hwb_status_pack #(.REV(REV)) u_stat (
        .selftest_ok(selftest_ok),
        .reset_pin  (reset_pin),
        .ch_en      (ch_en),
        .sync_in    (sync_in),
        .lvl_done   (lvl_done),
        .fifo_empty (fifo_empty),
        .word       (status_word)
    );

    assign addr_ok = (hst_addr[2] == 1'b0);
    assign wr_ev   = (state == S_IDLE) && fall[WR_IDX];
    assign rd_ev   = (state == S_IDLE) && !fall[WR_IDX] && fall[RD_IDX];

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (wr_ev)
                    state_nx = (addr_ok && hst_addr[1:0] == P_FETCH) ? S_RD_LAT : S_WR_HOLD;
                else if (rd_ev)
                    state_nx = S_RD_HOLD;
            end
            S_RD_LAT:  state_nx = S_RD_CAP;
            S_RD_CAP:  state_nx = S_WR_HOLD;
            S_WR_HOLD: if (lvl_n[WR_IDX]) state_nx = S_IDLE;
            S_RD_HOLD: if (lvl_n[RD_IDX]) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Output and datapath process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold       <= '0;
            rd_reg     <= '0;
            iaddr      <= '0;
            rd_is_fifo <= 1'b0;
            tgt_wr_stb <= 1'b0;
            tgt_rd_stb <= 1'b0;
            fifo_pop   <= 1'b0;
        end else begin
            tgt_wr_stb <= 1'b0;
            tgt_rd_stb <= 1'b0;
            fifo_pop   <= 1'b0;
            if (wr_ev && addr_ok) begin
                unique case (hst_addr[1:0])
                    P_LO:     hold[15:0]  <= hst_wdata;
                    P_HI:     hold[31:16] <= hst_wdata;
                    P_COMMIT: begin
                        iaddr      <= hst_wdata[IADDR_W-1:0];
                        tgt_wr_stb <= 1'b1;
                    end
                    P_FETCH:  begin
                        iaddr      <= hst_wdata[IADDR_W-1:0];
                        tgt_rd_stb <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (rd_ev)
                rd_is_fifo <= addr_ok && (hst_addr[1:0] == P_FIFO);
            if (state == S_RD_CAP)
                rd_reg <= tgt_rdata;
            if (state == S_RD_HOLD && lvl_n[RD_IDX])
                fifo_pop <= rd_is_fifo && !fifo_empty;
        end
    end

    assign tgt_addr  = iaddr;
    assign tgt_wdata = hold;

    // Host read mux
    always_comb begin
        hst_rdata = '0;
        if (addr_ok) begin
            unique case (hst_addr[1:0])
                P_LO:   hst_rdata = rd_reg[15:0];
                P_HI:   hst_rdata = rd_reg[31:16];
                P_FIFO: hst_rdata = fifo_data;
                P_STAT: hst_rdata = status_word;
                default: hst_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
    parameter int IADDR_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  hst_addr,
    input logic [15:0] hst_rdata,
    input logic        tgt_wr_stb,
    input logic        tgt_rd_stb,
    input logic        fifo_pop,
    input logic        fifo_empty,
    input logic [31:0] rd_reg
);
    // R2: write strobe lasts one cycle
    a_r2_wr_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr_stb |=> !tgt_wr_stb);

    // R3: read strobe lasts one cycle and never overlaps a write strobe
    a_r3_rd_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd_stb |=> !tgt_rd_stb);
    a_r3_stb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_wr_stb && tgt_rd_stb));

    // R5: pop lasts one cycle
    a_r5_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R6: no pop after an empty cycle
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !$past(fifo_empty));

    // R4: read register changes only two cycles after a read strobe
    a_r4_rdreg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reg != $past(rd_reg)) |-> $past(tgt_rd_stb, 2));

    // R7: top status bits are zero
    a_r7_status_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_addr == 3'd3) |-> (hst_rdata[15:13] == 3'b000));
endmodule

bind host_window_bridge hwb_checker #(.IADDR_W(IADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_addr  (hst_addr),
    .hst_rdata (hst_rdata),
    .tgt_wr_stb(tgt_wr_stb),
    .tgt_rd_stb(tgt_rd_stb),
    .fifo_pop  (fifo_pop),
    .fifo_empty(fifo_empty),
    .rd_reg    (rd_reg)
);

// File: tb/test_host_window_bridge.sv
module test_host_window_bridge;
    localparam int IADDR_W = 16;
    localparam int FDEPTH  = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2:0]         hst_addr = '0;
    logic [15:0]        hst_wdata = '0;
    logic               hst_wr_n = 1'b1;
    logic               hst_rd_n = 1'b1;
    logic [15:0]        hst_rdata;
    logic [IADDR_W-1:0] tgt_addr;
    logic [31:0]        tgt_wdata;
    logic               tgt_wr_stb, tgt_rd_stb;
    logic [31:0]        tgt_rdata = '0;
    logic [15:0]        fifo_data;
    logic               fifo_empty;
    logic               fifo_pop;
    logic               selftest_ok = 1'b0;
    logic               reset_pin = 1'b0;
    logic [3:0]         ch_en = '0;
    logic               sync_in = 1'b0;
    logic               lvl_done = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    host_window_bridge #(.IADDR_W(IADDR_W)) i_host_window_bridge (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_wr_n(hst_wr_n), .hst_rd_n(hst_rd_n), .hst_rdata(hst_rdata),
        .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_wr_stb(tgt_wr_stb),
        .tgt_rd_stb(tgt_rd_stb), .tgt_rdata(tgt_rdata), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .selftest_ok(selftest_ok),
        .reset_pin(reset_pin), .ch_en(ch_en), .sync_in(sync_in), .lvl_done(lvl_done)
    );

    // Target model: one-cycle read latency
    function automatic logic [31:0] tgt_value(input logic [15:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction
    always @(posedge clk) if (tgt_rd_stb) tgt_rdata <= tgt_value(tgt_addr);

    // FIFO model
    logic [15:0] fmem [FDEPTH] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};
    int f_n   = 3;
    int f_idx = 0;
    assign fifo_empty = (f_idx >= f_n);
    assign fifo_data  = fmem[(f_idx < f_n) ? f_idx : f_n - 1];
    always @(posedge clk) if (fifo_pop && f_idx < f_n) f_idx <= f_idx + 1;

    // Scoreboard
    typedef enum logic [1:0] {K_WR, K_RD, K_POP} kind_t;
    typedef struct {
        kind_t       kind;
        logic [15:0] addr;
        logic [31:0] data;
        string       req;
    } ev_t;
    ev_t exp_q[$];

    function automatic void check(input string req, input logic [31:0] act,
                                  input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endfunction

    task automatic expect_ev(input kind_t k, input logic [15:0] a,
                             input logic [31:0] d, input string req);
        ev_t e;
        e.kind = k; e.addr = a; e.data = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic see_ev(input kind_t k);
        ev_t e;
        if (exp_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R9: actual unexpected event kind %0d expected none", k);
        end else begin
            e = exp_q.pop_front();
            check(e.req, {30'd0, k}, {30'd0, e.kind});
            if (k != K_POP) check(e.req, {16'd0, tgt_addr}, {16'd0, e.addr});
            if (k == K_WR)  check(e.req, tgt_wdata, e.data);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (tgt_wr_stb) see_ev(K_WR);
            if (tgt_rd_stb) see_ev(K_RD);
            if (fifo_pop)   see_ev(K_POP);
        end
    end

    task automatic host_write(input logic [2:0] a, input logic [15:0] d,
                              input int hold_cyc);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr_n = 1'b0;
        repeat (hold_cyc) @(negedge clk);
        hst_wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(input logic [2:0] a, output logic [15:0] v,
                             input string req);
        logic [15:0] early;
        @(negedge clk);
        hst_addr = a; hst_rd_n = 1'b0;
        @(negedge clk);
        early = hst_rdata;
        repeat (4) @(negedge clk);
        v = hst_rdata;
        check(req, {16'd0, v}, {16'd0, early});  // stable through access
        hst_rd_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        if (exp_q.size() != 0) begin
            foreach (exp_q[i]) begin
                n_checks++; n_fail++;
                $display("FAIL %s: actual missing event expected kind %0d",
                         exp_q[i].req, exp_q[i].kind);
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11", {16'd0, tgt_addr}, 32'd0);
        check("R11", tgt_wdata, 32'd0);
        check("R11", {29'd0, tgt_wr_stb, tgt_rd_stb, fifo_pop}, 32'd0);
        host_read(3'd0, v, "R11"); check("R11", {16'd0, v}, 32'd0);

        // R1, R2: stage and commit
        host_write(3'd0, 16'hBEEF, 4);
        host_write(3'd1, 16'hDEAD, 4);
        check("R1", tgt_wdata, 32'hDEADBEEF);
        expect_ev(K_WR, 16'h0123, 32'hDEADBEEF, "R2");
        host_write(3'd2, 16'h0123, 4);
        check("R2", {16'd0, tgt_addr}, 32'h0123);

        // R3, R4: fetch and read halves
        expect_ev(K_RD, 16'h0456, 32'd0, "R3");
        host_write(3'd3, 16'h0456, 6);
        host_read(3'd0, v, "R4"); check("R4", {16'd0, v}, {16'd0, tgt_value(16'h0456)[15:0]});
        host_read(3'd1, v, "R4"); check("R4", {16'd0, v}, {16'd0, tgt_value(16'h0456)[31:16]});

        // R4: holds through other writes
        host_write(3'd0, 16'h0F0F, 4);
        expect_ev(K_WR, 16'h0777, 32'hDEAD0F0F, "R4");
        host_write(3'd2, 16'h0777, 4);
        host_read(3'd0, v, "R4"); check("R4", {16'd0, v}, {16'd0, tgt_value(16'h0456)[15:0]});

        // R9: long-held write gives one strobe
        expect_ev(K_WR, 16'h0999, 32'hDEAD0F0F, "R9");
        host_write(3'd2, 16'h0999, 25);

        // R10: inert addresses
        host_write(3'd4, 16'h1234, 4);
        host_write(3'd6, 16'h5678, 4);
        check("R10", tgt_wdata, 32'hDEAD0F0F);
        check("R10", {16'd0, tgt_addr}, 32'h0999);
        host_read(3'd5, v, "R10"); check("R10", {16'd0, v}, 32'd0);
        host_read(3'd7, v, "R10"); check("R10", {16'd0, v}, 32'd0);

        // R8: reads of 0,1,3 produce no events (monitor flags any)
        host_read(3'd1, v, "R8");
        host_read(3'd3, v, "R8");

        // R5: FIFO words in order with one pop each
        for (int i = 0; i < 3; i++) begin
            expect_ev(K_POP, 16'd0, 32'd0, "R5");
            host_read(3'd2, v, "R5");
            check("R5", {16'd0, v}, {16'd0, fmem[i]});
        end

        // R6: empty FIFO, no pop, last word shown
        host_read(3'd2, v, "R6");
        check("R6", {16'd0, v}, {16'd0, fmem[2]});

        // R7: status packing, two patterns
        selftest_ok = 1'b1; reset_pin = 1'b0; ch_en = 4'b0001; sync_in = 1'b0; lvl_done = 1'b1;
        host_read(3'd3, v, "R7");
        check("R7", {16'd0, v}, {16'd0, 3'b000, 1'b1, 1'b1, 4'b1000, 1'b0, 4'd3, 1'b1, 1'b1});
        f_n = 4;
        selftest_ok = 1'b0; reset_pin = 1'b1; ch_en = 4'b1010; sync_in = 1'b1; lvl_done = 1'b0;
        @(negedge clk);
        host_read(3'd3, v, "R7");
        check("R7", {16'd0, v}, {16'd0, 3'b000, 1'b0, 1'b0, 4'b0101, 1'b1, 4'd3, 1'b0, 1'b0});

        repeat (5) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule